// File: doc/BRIEF.md
# Infrared Receive Glitch Filter

This block sits between an active-low infrared receive pin and a UART receiver and removes short low-going noise spikes. The raw pin is first brought into the block clock domain by a chain of synchronizer flops. A falling edge on the synchronized line loads an 8-bit down-counter from a programmable prescaler, and the counter then decrements once per clock. A rising edge that arrives before the count runs out reloads the counter and discards the pulse as noise. If the line is still low when the count expires, the pulse is taken as a valid data zero.

Each accepted pulse drives the filtered receive line low for one bit period and then releases it high. The bit period is measured with a 16x baud tick supplied by the surrounding receiver. The prescaler sets the shortest low pulse that is accepted, and it is usually chosen to match the baud rate. A value of zero is treated as one.

Top module: `irda_rx_debounce`

## Requirements
- R1: While reset is asserted, and after release with the pin idle high, `rx_filt` is 1.
- R2: A low level on `rx_pin` that is sampled low on at least P consecutive rising clock edges is accepted, where P is `psc` (1..255). Counting the first edge that samples it low as edge 1, `rx_filt` goes low after edge P+2. This delay is two synchronizer stages plus one output register.
- R3: A low level on `rx_pin` that is sampled low on fewer than P consecutive edges leaves `rx_filt` high.
- R4: `psc` = 0 acts exactly like `psc` = 1, so a single sampled low is accepted.
- R5: After it falls, `rx_filt` stays low until it has seen 16 clock edges with `tick16` high. The tick in the edge that drives it low is not counted. It returns high on the 16th such edge.
- R6: One low pulse gives at most one acceptance. If the pin is held low longer than a bit period, `rx_filt` still returns high after 16 ticks and stays high until a new falling edge is accepted.
- R7: An acceptance while `rx_filt` is already low restarts the bit period, even when it falls on the same edge as the 16th tick. The line then stays low for 16 further ticks.
- R8: A rising edge reloads the counter, so short low pulses separated by short high gaps never add up to an acceptance.
- R9: The full 8-bit prescaler range is honoured: with `psc` = 255, a 254-cycle low is rejected and a 255-cycle low is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| rx_pin | input | 1 | Raw active-low infrared receive input, asynchronous |
| psc | input | 8 | Minimum accepted low width in clock cycles (0 treated as 1) |
| tick16 | input | 1 | One-cycle strobe at 16 times the baud rate |
| rx_filt | output | 1 | Filtered receive line for the UART receiver, idle high |

## Verification
Two events can land on the same clock edge: a newly accepted pulse, and the 16th baud tick that would end the current bit period. The bench stops the free-running tick generator and delivers 15 ticks by hand after a first acceptance. It then launches a second pulse and times a manual tick to meet the edge on which that pulse is accepted. The test passes only if `rx_filt` stays low through that edge and then needs exactly 16 more ticks to rise.

// File: rtl/irda_dbf_pkg.sv
package irda_dbf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DONE  = 2'd2
  } dbf_state_e;
endpackage

// File: rtl/irda_dbf_sync.sv
module irda_dbf_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_n;

  always_comb begin
    sr_n = {sr_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= {STAGES{RST_VAL}};
    else        sr_q <= sr_n;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/irda_dbf_count.sv
module irda_dbf_count
  import irda_dbf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_s,
  input  logic [CNT_W-1:0] psc,
  output logic             hit
);
  dbf_state_e       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, psc_eff;
  logic             rx_d_q;
  logic             fall, rise, cnt_en;

  always_comb begin
    fall    = rx_d_q & ~rx_s;
    rise    = ~rx_d_q & rx_s;
    psc_eff = (psc == '0) ? CNT_W'(1) : psc;
    st_n    = st_q;
    cnt_n   = cnt_q;
    hit     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cnt_n = psc_eff;
        if (fall) begin
          if (psc_eff == CNT_W'(1)) begin
            hit  = 1'b1;
            st_n = ST_DONE;
          end else begin
            cnt_n = psc_eff - CNT_W'(1);
            st_n  = ST_COUNT;
          end
        end
      end
      ST_COUNT: begin
        if (rise) begin
          cnt_n = psc_eff;
          st_n  = ST_IDLE;
        end else if (cnt_q == CNT_W'(1)) begin
          hit   = 1'b1;
          cnt_n = '0;
          st_n  = ST_DONE;
        end else begin
          cnt_n = cnt_q - CNT_W'(1);
        end
      end
      ST_DONE: begin
        if (rise) begin
          cnt_n = psc_eff;
          st_n  = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    cnt_en = (cnt_n != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rx_d_q <= 1'b1;
    end else begin
      st_q   <= st_n;
      rx_d_q <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  // R3 / R8: a rise during counting discards the pulse
  a_r3_rise_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COUNT && rx_s) |-> !hit);
  // R6: one acceptance per pulse
  a_r6_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
  // R2: a live count never sits at zero
  a_r2_cnt_live: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COUNT) |-> (cnt_q != '0));
  // R8: after a rise the counter is reloaded and idle
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_COUNT && rx_s) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/irda_dbf_stretch.sv
module irda_dbf_stretch #(
  parameter int BIT_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic tick,
  output logic rx_filt
);
  localparam int TCNT_W = $clog2(BIT_TICKS);

  logic              out_q, out_n;
  logic [TCNT_W-1:0] tcnt_q, tcnt_n;

  always_comb begin
    out_n  = out_q;
    tcnt_n = tcnt_q;
    if (hit) begin
      out_n  = 1'b0;
      tcnt_n = '0;
    end else if (!out_q && tick) begin
      if (tcnt_q == TCNT_W'(BIT_TICKS - 1)) begin
        out_n  = 1'b1;
        tcnt_n = '0;
      end else begin
        tcnt_n = tcnt_q + TCNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b1;
      tcnt_q <= '0;
    end else begin
      out_q  <= out_n;
      tcnt_q <= tcnt_n;
    end
  end

  assign rx_filt = out_q;

  // R5: the output only falls on an acceptance
  a_r5_fall_from_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_filt) |-> $past(hit));
  // R5 / R7: the output only rises on a tick with no acceptance
  a_r5_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_filt) |-> ($past(tick) && !$past(hit)));
  // R7: an acceptance always leaves the line low
  a_r7_hit_low: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !rx_filt);
endmodule

// File: rtl/irda_rx_debounce.sv
module irda_rx_debounce #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BIT_TICKS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_pin,
  input  logic [CNT_W-1:0] psc,
  input  logic             tick16,
  output logic             rx_filt
);
  logic rx_s;
  logic hit;

  irda_dbf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_pin), .q(rx_s)
  );

  irda_dbf_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .psc(psc), .hit(hit)
  );

  irda_dbf_stretch #(.BIT_TICKS(BIT_TICKS)) u_stretch (
    .clk(clk), .rst_n(rst_n), .hit(hit), .tick(tick16), .rx_filt(rx_filt)
  );

  // R1: an idle synchronized line never produces a low output on its own
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_filt) |-> $past(!rx_s));
endmodule

// File: tb/test_irda_rx_debounce.sv
`timescale 1ns/1ps
module test_irda_rx_debounce;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_pin;
  logic [7:0] psc;
  logic       tick16;
  logic       rx_filt;
  logic       tick_auto;
  logic       tick_man;
  int         errors = 0;
  int         checks = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  irda_rx_debounce i_irda_rx_debounce (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .psc(psc),
    .tick16(tick16), .rx_filt(rx_filt)
  );

  always @(negedge clk) begin
    if (tick_auto) tick16 <= ~tick16;
    else           tick16 <= tick_man;
  end

  typedef struct packed {
    logic [7:0]  p;
    logic [15:0] len;
    logic [15:0] first;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'd4,   16'd3,   16'd0},    // R3 one short
    '{8'd4,   16'd4,   16'd6},    // R2 exact
    '{8'd4,   16'd9,   16'd6},    // R2 longer
    '{8'd1,   16'd1,   16'd3},    // R2 minimum
    '{8'd0,   16'd1,   16'd3},    // R4 zero as one
    '{8'd0,   16'd3,   16'd3},    // R4
    '{8'd3,   16'd2,   16'd0},    // R3
    '{8'd8,   16'd7,   16'd0},    // R3
    '{8'd8,   16'd17,  16'd10},   // R2 beyond twice the prescaler
    '{8'd2,   16'd100, 16'd4},    // R6 held low past a bit
    '{8'd255, 16'd254, 16'd0},    // R9 reject
    '{8'd255, 16'd255, 16'd257}   // R9 accept
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int first = 0, falls = 0, rises = 0, ticks = 0;
    logic prev, cur, tk;
    string lbl;
    lbl = (v.first == 0) ? "R3 reject" : "R2 accept";
    @(posedge clk); #1 psc = v.p;
    @(posedge clk); #1 rx_pin = 1'b0;
    prev = rx_filt;
    for (int n = 1; n <= int'(v.len) + int'(v.p) + 60; n++) begin
      @(posedge clk);
      tk = tick16;
      #1 cur = rx_filt;
      if (n == int'(v.len)) rx_pin = 1'b1;
      if (prev && !cur) begin falls++; if (first == 0) first = n; end
      if (!prev && tk) ticks++;
      if (!prev && cur) rises++;
      prev = cur;
    end
    chk(first == int'(v.first), lbl, first, int'(v.first));
    if (v.first != 0) begin
      chk(falls == 1, "R6 single acceptance", falls, 1);
      chk(ticks == 16, "R5 ticks while low", ticks, 16);
      chk(rises == 1 && cur, "R5 released high", rises, 1);
    end else begin
      chk(falls == 0, "R3 no output", falls, 0);
    end
  endtask

  task automatic give_tick();
    @(posedge clk); #1 tick_man = 1'b1;
    @(posedge clk); #1 tick_man = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic seen;
    rst_n = 1'b0; rx_pin = 1'b1; psc = 8'd4; tick_auto = 1'b1; tick_man = 1'b0;
    tick16 = 1'b0;
    #20;
    chk(rx_filt == 1'b1, "R1 reset", rx_filt, 1);
    @(negedge clk); rst_n = 1'b1;
    repeat (10) @(posedge clk);
    #1 chk(rx_filt == 1'b1, "R1 idle", rx_filt, 1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R8: repeated short lows with short gaps never accumulate
    @(posedge clk); #1 psc = 8'd5;
    seen = 1'b0;
    for (int r = 0; r < 6; r++) begin
      for (int c = 0; c < 5; c++) begin
        @(posedge clk); #1 rx_pin = (c == 4);
        if (!rx_filt) seen = 1'b1;
      end
    end
    repeat (8) begin @(posedge clk); #1 if (!rx_filt) seen = 1'b1; end
    chk(!seen, "R8 reload on rise", seen, 0);

    // R7: acceptance on the same edge as the 16th tick
    @(posedge clk); #1 tick_auto = 1'b0; tick_man = 1'b0; psc = 8'd2;
    repeat (3) @(posedge clk);
    #1 rx_pin = 1'b0;
    repeat (3) @(posedge clk);
    #1 rx_pin = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk(rx_filt == 1'b0, "R7 first pulse accepted", rx_filt, 0);
    repeat (15) give_tick();
    repeat (2) @(posedge clk);
    #1 chk(rx_filt == 1'b0, "R5 low after 15 ticks", rx_filt, 0);
    rx_pin = 1'b0;                       // after P0
    @(posedge clk); @(posedge clk);      // P1, P2
    @(posedge clk); #1 tick_man = 1'b1; rx_pin = 1'b1;  // after P3
    @(posedge clk); #1 tick_man = 1'b0;  // after P4: hit and 16th tick together
    chk(rx_filt == 1'b0, "R7 restart wins over tick", rx_filt, 0);
    repeat (15) give_tick();
    repeat (2) @(posedge clk);
    #1 chk(rx_filt == 1'b0, "R7 still low after 15 new ticks", rx_filt, 0);
    give_tick();
    #1 chk(rx_filt == 1'b1, "R7 high after 16 new ticks", rx_filt, 1);
    tick_auto = 1'b1;
    repeat (5) @(posedge clk);

    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule